// File: doc/BRIEF.md
# Three-Wire Serial Shifter

This block moves one byte at a time over a synchronous serial link made of a clock line, a data-in line and a data-out line. Both directions run in the same transfer: while the local byte leaves on the data-out line, most significant bit first, a byte from the far end arrives on the data-in line and fills the same shift register from the bottom.

The block works as clock master or as clock slave. As master it makes the serial clock from its own system clock (the instruction clock) through a divider picked by two control bits. As slave it follows a clock that another device drives, and the divider setting has no effect. Software writes the byte to send, picks the mode and the rate, and then sets the busy flag in the status word to start. After eight bits the busy flag drops by itself and a pending flag raises the interrupt line until software clears it. Chip selects are driven by general-purpose I/O and are not part of this block.

Top module: `tri_wire_shifter`

## Requirements
- R1: After reset the data register, busy flag, pending flag, interrupt, serial clock output, clock output enable and data-out line are all zero.
- R2: Register map by `reg_addr`: 0 is the data byte, 1 is control (bits 1:0 rate code, bit 2 master mode), 2 is status (bit 0 busy, bit 1 pending). `reg_rdata` shows the register selected in the previous cycle.
- R3: Writing status with bit 0 set while idle starts a transfer, and status bit 0 then reads 1 until the transfer ends.
- R4: The data-out line carries bit 7 of the data register. It moves to the next bit after each falling serial clock edge, so the far end sees the loaded byte most significant bit first.
- R5: The data-in line is sampled on each rising serial clock edge. After eight bits the data register holds the received byte, first bit in bit 7.
- R6: In master mode the clock output enable is 1 and one serial clock period lasts 2, 4 or 8 system clocks for rate codes 00, 01 and 1x. The serial clock output idles low.
- R7: In slave mode the clock output enable is 0, the serial clock output stays low, the rate code has no effect, and edges on `sk_in` clock the transfer.
- R8: After the eighth falling edge, busy clears and the pending flag and `irq` go high in the same cycle. Writing status with bit 1 set clears the pending flag.
- R9: A write to the data register while busy is set is ignored.
- R10: Serial clock edges while no transfer is running leave the data register unchanged and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (instruction) clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| sk_in | input | 1 | Serial clock from the far end (slave mode) |
| sk_out | output | 1 | Serial clock driven in master mode |
| sk_oe | output | 1 | Output enable for the serial clock pin |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
The bench acts as the far-end device. It shifts a byte into `si` on falling clock edges and records `so` on rising ones, so a design that reverses the bit order or samples on the wrong edge returns a mismatched byte in one direction or the other. It measures the serial clock period at every rate code, including code 11 that must act like 10, where a wrong divider shows up as a wrong period. Slave transfers run with a fast rate code to show that the divider is ignored and `sk_out` never moves. Directed cases write the data register in the middle of a transfer and toggle the clock while idle; a design that accepted either would end with a corrupted byte or a stray interrupt.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } tws_reg_e;

  localparam int CTRL_MASTER_BIT = 2;
  localparam int STAT_BUSY_BIT   = 0;
  localparam int STAT_PEND_BIT   = 1;
  localparam int HALF_W          = 3;

  // system clocks per serial-clock half period for a rate code
  function automatic logic [HALF_W-1:0] half_len(input logic [1:0] code);
    case (code)
      2'd0:    half_len = HALF_W'(1);
      2'd1:    half_len = HALF_W'(2);
      default: half_len = HALF_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/tws_rate_gen.sv
module tws_rate_gen #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == (half - ONE));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + ONE;
  end
endmodule

// File: rtl/tws_sk_sync.sv
module tws_sk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sk_pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= sk_pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], sk_pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] && !prev;
  assign fall = !chain[STAGES-1] && prev;
endmodule

// File: rtl/tws_shift_eng.sv
module tws_shift_eng #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         start,
  input  logic         edge_rise,
  input  logic         edge_fall,
  input  logic         sdi,
  output logic [W-1:0] sr,
  output logic         busy,
  output logic         done
);
  localparam int            CW   = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bitcnt;
  logic          hold;

  assign done = busy && edge_fall && (bitcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      busy   <= 1'b0;
      bitcnt <= '0;
      hold   <= 1'b0;
    end else if (!busy) begin
      if (load) sr <= load_data;
      if (start) begin
        busy   <= 1'b1;
        bitcnt <= '0;
      end
    end else begin
      if (edge_rise) hold <= sdi;
      if (edge_fall) begin
        sr     <= {sr[W-2:0], hold};
        bitcnt <= bitcnt + CW'(1);
        if (bitcnt == LAST) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tri_wire_shifter.sv
module tri_wire_shifter #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         sk_in,
  output logic         sk_out,
  output logic         sk_oe,
  input  logic         si,
  output logic         so,
  output logic         irq
);
  import tws_pkg::*;

  logic [1:0]   cfg_rate;
  logic         cfg_master;
  logic         pend;
  logic         sk_q;
  logic         m_tick, s_rise, s_fall;
  logic         shift_rise, shift_fall;
  logic         load_req, start_req, pend_clr;
  logic [W-1:0] sr;
  logic         busy, done;

  assign load_req  = reg_wr && (reg_addr == REG_DATA);
  assign start_req = reg_wr && (reg_addr == REG_STAT) && reg_wdata[STAT_BUSY_BIT];
  assign pend_clr  = reg_wr && (reg_addr == REG_STAT) && reg_wdata[STAT_PEND_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rate   <= 2'd0;
      cfg_master <= 1'b0;
    end else if (reg_wr && (reg_addr == REG_CTRL)) begin
      cfg_rate   <= reg_wdata[1:0];
      cfg_master <= reg_wdata[CTRL_MASTER_BIT];
    end
  end

  tws_rate_gen #(.CNT_W(HALF_W)) u_rate (
    .clk  (clk),
    .rst  (rst),
    .run  (busy && cfg_master),
    .half (half_len(cfg_rate)),
    .tick (m_tick)
  );

  always_ff @(posedge clk) begin
    if (rst || !(busy && cfg_master)) sk_q <= 1'b0;
    else if (m_tick)                  sk_q <= !sk_q;
  end

  tws_sk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sk_pin (sk_in),
    .rise   (s_rise),
    .fall   (s_fall)
  );

  assign shift_rise = cfg_master ? (m_tick && !sk_q) : s_rise;
  assign shift_fall = cfg_master ? (m_tick &&  sk_q) : s_fall;

  tws_shift_eng #(.W(W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .load      (load_req),
    .load_data (reg_wdata),
    .start     (start_req),
    .edge_rise (shift_rise),
    .edge_fall (shift_fall),
    .sdi       (si),
    .sr        (sr),
    .busy      (busy),
    .done      (done)
  );

  always_ff @(posedge clk) begin
    if (rst)           pend <= 1'b0;
    else if (done)     pend <= 1'b1;
    else if (pend_clr) pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        REG_DATA: reg_rdata <= sr;
        REG_CTRL: reg_rdata <= {{(W-3){1'b0}}, cfg_master, cfg_rate};
        REG_STAT: reg_rdata <= {{(W-2){1'b0}}, pend, busy};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign sk_out = sk_q;
  assign sk_oe  = cfg_master;
  assign so     = sr[W-1];
  assign irq    = pend;
endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic [W-1:0] sr,
  input logic         shift_fall,
  input logic         start_req,
  input logic         cfg_master,
  input logic         sk_out,
  input logic         irq
);
  // R3: a start request while idle makes the transfer begin
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (start_req && !busy) |=> busy);

  // R6: the serial clock output rests low when no transfer runs
  p_idle_sk_low_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !sk_out);

  // R7: in slave mode the clock output never goes high
  p_slave_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_master |=> !sk_out);

  // R8: end of transfer and interrupt arrive together
  p_done_irq_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);

  // R9: during a transfer the register only moves on a falling serial edge
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !shift_fall) |=> (sr == $past(sr)));
endmodule

bind tri_wire_shifter tws_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .sr         (sr),
  .shift_fall (shift_fall),
  .start_req  (start_req),
  .cfg_master (cfg_master),
  .sk_out     (sk_out),
  .irq        (irq)
);

// File: tb/sim_tri_wire_shifter.sv
`timescale 1ns/1ps
module sim_tri_wire_shifter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sk_in = 1'b0;
  logic       sk_out, sk_oe, so, irq;
  logic       si;

  always #5 clk = ~clk;

  // far-end model state
  logic       vmaster = 1'b0;
  logic [7:0] rx_cur  = 8'd0;
  logic [7:0] rcap    = 8'd0;
  int         ridx    = 0;
  int         rises   = 0;
  int         last_rise = 0;
  int         period  = 0;
  logic       sk_prev = 1'b0;
  logic       sk_seen = 1'b0;
  int         cyc     = 0;
  int         n_chk   = 0;
  int         n_bad   = 0;

  assign si = (ridx < 8) ? rx_cur[7 - ridx] : 1'b0;

  tri_wire_shifter u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sk_in(sk_in),
    .sk_out(sk_out), .sk_oe(sk_oe), .si(si), .so(so), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog R8 act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    logic line;
    line = vmaster ? sk_out : sk_in;
    if (sk_out) sk_seen = 1'b1;
    if (line && !sk_prev) begin
      rcap  = {rcap[6:0], so};
      rises = rises + 1;
      if (rises == 2) period = cyc - last_rise;
      last_rise = cyc;
    end
    if (!line && sk_prev) ridx = ridx + 1;
    sk_prev = line;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    step(1);
    v = reg_rdata;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic far_reset(input logic m, input logic [7:0] rx);
    vmaster = m; rx_cur = rx; rcap = 8'd0; ridx = 0;
    rises = 0; period = 0; sk_seen = 1'b0;
  endtask

  task automatic wait_irq();
    int k;
    k = 0;
    while (!irq && k < 3000) begin
      step(1);
      k++;
    end
    check("R8 irq after eighth bit", int'(irq), 1);
  endtask

  task automatic slave_clock(input int bits);
    for (int b = 0; b < bits; b++) begin
      step(4); sk_in = 1'b1;
      step(4); sk_in = 1'b0;
    end
    step(4);
  endtask

  // {master, rate[1:0], tx[7:0], rx[7:0]}
  localparam logic [18:0] VEC [6] = '{
    {1'b1, 2'd0, 8'hA5, 8'h3C},
    {1'b1, 2'd1, 8'h81, 8'h7E},
    {1'b1, 2'd2, 8'h0F, 8'hF0},
    {1'b1, 2'd3, 8'h00, 8'hFF},
    {1'b0, 2'd0, 8'hC6, 8'h59},
    {1'b0, 2'd3, 8'hFF, 8'h01}
  };

  initial begin
    logic [7:0] v;
    step(4);
    rst = 1'b0;
    step(1);

    // R1 reset state
    check("R1 irq", int'(irq), 0);
    check("R1 sk_out", int'(sk_out), 0);
    check("R1 sk_oe", int'(sk_oe), 0);
    check("R1 so", int'(so), 0);
    rd(2'd0, v); check("R1 data", int'(v), 0);
    rd(2'd2, v); check("R1 status", int'(v), 0);

    for (int n = 0; n < 6; n++) begin
      logic       m;
      logic [1:0] rate;
      logic [7:0] tx, rx;
      int         expdiv;
      {m, rate, tx, rx} = VEC[n];
      expdiv = (rate == 2'd0) ? 2 : (rate == 2'd1) ? 4 : 8;
      wr(2'd1, {5'd0, m, rate});
      rd(2'd1, v); check("R2 control readback", int'(v), int'({5'd0, m, rate}));
      wr(2'd0, tx);
      wr(2'd2, 8'h02);
      far_reset(m, rx);
      check("R4 so shows bit 7 before start", int'(so), int'(tx[7]));
      wr(2'd2, 8'h01);
      rd(2'd2, v); check("R3 busy after start", int'(v[0]), 1);
      if (!m) slave_clock(8);
      wait_irq();
      check("R4 far end received loaded byte", int'(rcap), int'(tx));
      rd(2'd0, v); check("R5 data holds received byte", int'(v), int'(rx));
      rd(2'd2, v); check("R8 status busy clear pending set", int'(v[1:0]), 2);
      if (m) begin
        check("R6 serial clock period", period, expdiv);
        check("R6 sk_oe in master", int'(sk_oe), 1);
      end else begin
        check("R7 sk_out never high in slave", int'(sk_seen), 0);
        check("R7 sk_oe in slave", int'(sk_oe), 0);
      end
    end

    // R8 pending cleared by status bit 1
    wr(2'd2, 8'h02);
    check("R8 irq cleared", int'(irq), 0);
    rd(2'd2, v); check("R8 pending bit cleared", int'(v[1]), 0);

    // R9 data write in mid-transfer is ignored
    wr(2'd1, 8'h06);
    wr(2'd0, 8'h5A);
    far_reset(1'b1, 8'hC3);
    wr(2'd2, 8'h01);
    step(10);
    wr(2'd0, 8'hFF);
    rd(2'd2, v); check("R3 busy still set mid-transfer", int'(v[0]), 1);
    wait_irq();
    rd(2'd0, v); check("R9 write while busy ignored", int'(v), 8'hC3);
    check("R9 far end got original byte", int'(rcap), 8'h5A);
    wr(2'd2, 8'h02);

    // R10 slave edges while idle do nothing
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h3C);
    far_reset(1'b0, 8'hFF);
    slave_clock(3);
    rd(2'd0, v); check("R10 data unchanged by idle edges", int'(v), 8'h3C);
    check("R10 no interrupt from idle edges", int'(irq), 0);
    rd(2'd2, v); check("R10 busy not set by idle edges", int'(v[0]), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule